// File: doc/BRIEF.md
# General-Purpose I/O Port with Edge Interrupts

This block controls a bank of general-purpose pins, eight by default, through a small register interface. Each pin has its own configuration bits: a function select, a direction, an output level, a pull enable, an edge polarity, an interrupt enable and a latched event flag. A pin can be handed to an internal peripheral signal, or it can stay under port control as an input or an output.

Pin levels go through a synchronizer before software reads them or the edge logic sees them. Each pin flags the edge polarity chosen for it. The flags stay set until software writes them. The port raises a single interrupt request whenever an enabled pin holds a flag.

The output register has a second use. When a pin is a port-controlled input with its pull enabled, the output bit chooses between pull-up and pull-down.

Top module: `gpio_edge_port`

## Requirements
- R1: After reset every configuration register and every flag is 0, so pad_oe_o, the pull controls and irq_o are all 0.
- R2: Register addresses are fixed: 0 input level (read only), 1 output level, 2 direction, 3 pull enable, 4 function select, 5 edge polarity, 6 interrupt enable, 7 flags. Bit n of every register belongs to pin n, and a read returns the addressed register combinationally.
- R3: With function select 0, pad_oe_o[n] equals direction bit n (1 = output) and pad_out_o[n] equals output bit n.
- R4: With function select 1, pad_out_o[n] and pad_oe_o[n] follow alt_out_i[n] and alt_oe_i[n], whatever the port's own direction and output bits hold.
- R5: The input register gives the pin level after a two-flop synchronizer. A change on pin_i appears on a read after the second rising clock edge. The output register never changes what the input register returns.
- R6: Edge polarity 0 sets the pin's flag on a synchronized low-to-high transition. The flag is set at the third rising edge after the pin changes.
- R7: Edge polarity 1 sets the pin's flag on a high-to-low transition. A transition in the other direction leaves the flag unchanged.
- R8: irq_o is 1 exactly when some pin has both its flag and its interrupt enable at 1.
- R9: A write to the flag register loads the written value, so writing 0 clears a flag and writing 1 sets it.
- R10: When a flag write happens in the same cycle as a detected edge on a pin, that pin's flag ends up 1.
- R11: Writing the edge polarity register while the pins are steady does not change any flag.
- R12: For a port-controlled input (function select 0, direction 0) with pull enable 1, output bit 1 drives pull_up_o and output bit 0 drives pull_down_o. With pull enable 0, or for any other pin, both pull controls are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 3 | Register address |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | NUM_PINS | Write data |
| reg_rdata_o | output | NUM_PINS | Read data of the addressed register |
| pin_i | input | NUM_PINS | Pin levels from the pads |
| alt_out_i | input | NUM_PINS | Peripheral output level per pin |
| alt_oe_i | input | NUM_PINS | Peripheral output enable per pin |
| pad_out_o | output | NUM_PINS | Level driven to the pads |
| pad_oe_o | output | NUM_PINS | Pad output enable |
| pull_up_o | output | NUM_PINS | Pull-up enable per pin |
| pull_down_o | output | NUM_PINS | Pull-down enable per pin |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The most delicate case is a flag write that falls in the same cycle as an edge. If the write took priority there, the event would be lost and the flag would read 0. Reversing the polarity must set flags only on the opposite transitions, so the bench drives random pin changes under random polarities. A design that also armed on the wrong edge would show extra flags. Changing the polarity while pins are steady must not create an event, which a detector that compares a polarity-adjusted level against its own history would do. The bench also measures the input read latency, which shows a missing or extra synchronizer stage, and checks that pulls follow the output bit only for port-controlled inputs.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_IN   = 3'd0,
    REG_OUT  = 3'd1,
    REG_DIR  = 3'd2,
    REG_PULL = 3'd3,
    REG_FSEL = 3'd4,
    REG_EDGE = 3'd5,
    REG_IEN  = 3'd6,
    REG_FLAG = 3'd7
  } gpio_reg_e;
endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 8,
  parameter int unsigned STAGES   = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  output logic [NUM_PINS-1:0] sync_o,
  output logic [NUM_PINS-1:0] prev_o
);
  localparam int unsigned LAST = STAGES - 1;

  logic [NUM_PINS-1:0] chain_q [STAGES];
  logic [NUM_PINS-1:0] prev_q;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[0] <= '0;
        else         chain_q[0] <= pin_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[s] <= '0;
        else         chain_q[s] <= chain_q[s-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= chain_q[LAST];
  end

  assign sync_o = chain_q[LAST];
  assign prev_o = prev_q;
endmodule

// File: rtl/gpio_edge_detect.sv
module gpio_edge_detect #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic [NUM_PINS-1:0] cur_i,
  input  logic [NUM_PINS-1:0] prev_i,
  input  logic [NUM_PINS-1:0] fall_sel_i,
  output logic [NUM_PINS-1:0] hit_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic rise, fall;
    assign rise     = cur_i[p] & ~prev_i[p];
    assign fall     = ~cur_i[p] & prev_i[p];
    assign hit_o[p] = fall_sel_i[p] ? fall : rise;
  end
endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
  parameter int unsigned NUM_PINS = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] fsel_i,
  input  logic [NUM_PINS-1:0] dir_i,
  input  logic [NUM_PINS-1:0] out_i,
  input  logic [NUM_PINS-1:0] pull_i,
  input  logic [NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_PINS-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_down_o
);
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic gpio_in;
    assign gpio_in        = ~fsel_i[p] & ~dir_i[p];
    assign pad_out_o[p]   = fsel_i[p] ? alt_out_i[p] : out_i[p];
    assign pad_oe_o[p]    = fsel_i[p] ? alt_oe_i[p]  : dir_i[p];
    assign pull_up_o[p]   = gpio_in & pull_i[p] &  out_i[p];
    assign pull_down_o[p] = gpio_in & pull_i[p] & ~out_i[p];
  end

  assert_pull_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pull_up_o & pull_down_o) == '0);

  // a pull never fights a port-driven output
  assert_pull_not_driven_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pull_up_o | pull_down_o) & ~fsel_i & dir_i) == '0);
endmodule

// File: rtl/gpio_edge_port.sv
module gpio_edge_port
  import gpio_edge_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   reg_addr_i,
  input  logic                reg_we_i,
  input  logic [NUM_PINS-1:0] reg_wdata_i,
  output logic [NUM_PINS-1:0] reg_rdata_o,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic [NUM_PINS-1:0] alt_out_i,
  input  logic [NUM_PINS-1:0] alt_oe_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o,
  output logic [NUM_PINS-1:0] pull_up_o,
  output logic [NUM_PINS-1:0] pull_down_o,
  output logic                irq_o
);
  logic [NUM_PINS-1:0] out_q, dir_q, pull_q, fsel_q, edge_q, ien_q, flag_q;
  logic [NUM_PINS-1:0] sync_lvl, prev_lvl, edge_hit;
  gpio_reg_e           sel;

  assign sel = gpio_reg_e'(reg_addr_i);

  gpio_in_sync #(.NUM_PINS(NUM_PINS), .STAGES(SYNC_STAGES)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (pin_i),
    .sync_o (sync_lvl),
    .prev_o (prev_lvl)
  );

  gpio_edge_detect #(.NUM_PINS(NUM_PINS)) i_edge (
    .cur_i      (sync_lvl),
    .prev_i     (prev_lvl),
    .fall_sel_i (edge_q),
    .hit_o      (edge_hit)
  );

  gpio_pad_ctrl #(.NUM_PINS(NUM_PINS)) i_pad (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fsel_i      (fsel_q),
    .dir_i       (dir_q),
    .out_i       (out_q),
    .pull_i      (pull_q),
    .alt_out_i   (alt_out_i),
    .alt_oe_i    (alt_oe_i),
    .pad_out_o   (pad_out_o),
    .pad_oe_o    (pad_oe_o),
    .pull_up_o   (pull_up_o),
    .pull_down_o (pull_down_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_q  <= '0;
      dir_q  <= '0;
      pull_q <= '0;
      fsel_q <= '0;
      edge_q <= '0;
      ien_q  <= '0;
    end else if (reg_we_i) begin
      case (sel)
        REG_OUT:  out_q  <= reg_wdata_i;
        REG_DIR:  dir_q  <= reg_wdata_i;
        REG_PULL: pull_q <= reg_wdata_i;
        REG_FSEL: fsel_q <= reg_wdata_i;
        REG_EDGE: edge_q <= reg_wdata_i;
        REG_IEN:  ien_q  <= reg_wdata_i;
        default: ;
      endcase
    end
  end

  // detected edges win over a simultaneous software write
  logic flag_wr;
  assign flag_wr = reg_we_i && (sel == REG_FLAG);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= '0;
    else         flag_q <= (flag_wr ? reg_wdata_i : flag_q) | edge_hit;
  end

  always_comb begin
    case (sel)
      REG_IN:   reg_rdata_o = sync_lvl;
      REG_OUT:  reg_rdata_o = out_q;
      REG_DIR:  reg_rdata_o = dir_q;
      REG_PULL: reg_rdata_o = pull_q;
      REG_FSEL: reg_rdata_o = fsel_q;
      REG_EDGE: reg_rdata_o = edge_q;
      REG_IEN:  reg_rdata_o = ien_q;
      default:  reg_rdata_o = flag_q;
    endcase
  end

  assign irq_o = |(flag_q & ien_q);

  // a flag only rises from an edge or a flag write
  assert_flag_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flag_wr |=> ((flag_q & ~$past(flag_q) & ~$past(edge_hit)) == '0));

  assert_edge_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_hit != '0) |=> ((flag_q & $past(edge_hit)) == $past(edge_hit)));

  assert_polarity_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && sel == REG_EDGE && sync_lvl == prev_lvl) |=> (flag_q == $past(flag_q)));

  assert_irq_needs_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_q == '0) |-> !irq_o);
endmodule

// File: tb/test_gpio_edge_port.sv
`timescale 1ns/1ps
module test_gpio_edge_port;
  localparam int N = 8;

  logic         clk_i = 0, rst_ni = 0;
  logic [2:0]   reg_addr_i = 0;
  logic         reg_we_i = 0;
  logic [N-1:0] reg_wdata_i = 0, reg_rdata_o;
  logic [N-1:0] pin_i = 0, alt_out_i = 0, alt_oe_i = 0;
  logic [N-1:0] pad_out_o, pad_oe_o, pull_up_o, pull_down_o;
  logic         irq_o;

  int total = 0, bad = 0;

  // model state
  logic [N-1:0] m_out = 0, m_dir = 0, m_pull = 0, m_fsel = 0, m_edge = 0, m_ien = 0, m_flag = 0, m_pin = 0;

  gpio_edge_port #(.NUM_PINS(N)) i_gpio_edge_port (.*);

  always #4 clk_i = ~clk_i;

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wdata_i = d; reg_we_i = 1;
    @(negedge clk_i);
    reg_we_i = 0;
    case (a)
      3'd1: m_out = d;  3'd2: m_dir = d;  3'd3: m_pull = d;
      3'd4: m_fsel = d; 3'd5: m_edge = d; 3'd6: m_ien = d;
      3'd7: m_flag = d; default: ;
    endcase
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  function automatic logic [N-1:0] exp_hits(logic [N-1:0] o, logic [N-1:0] n, logic [N-1:0] es);
    return ((n & ~o) & ~es) | ((~n & o) & es);
  endfunction

  function automatic logic [N-1:0] exp_pad_out();
    return (m_fsel & alt_out_i) | (~m_fsel & m_out);
  endfunction

  function automatic logic [N-1:0] exp_pad_oe();
    return (m_fsel & alt_oe_i) | (~m_fsel & m_dir);
  endfunction

  task automatic settle(logic [N-1:0] p);
    @(negedge clk_i);
    pin_i = p;
    repeat (4) @(negedge clk_i);
    m_flag = m_flag | exp_hits(m_pin, p, m_edge);
    m_pin = p;
  endtask

  task automatic check_pads(string req);
    chk(req, pad_out_o, exp_pad_out());
    chk(req, pad_oe_o, exp_pad_oe());
    chk("R12", pull_up_o, ~m_fsel & ~m_dir & m_pull & m_out);
    chk("R12", pull_down_o, ~m_fsel & ~m_dir & m_pull & ~m_out);
  endtask

  initial begin
    #(8 * 150000);
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R1 reset state, R2 map
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], d);
      chk("R1", d, '0);
    end
    chk("R1", pad_oe_o, '0);
    chk("R1", pull_up_o | pull_down_o, '0);
    chk("R1", {7'd0, irq_o}, '0);

    // R2 readback of each writable register
    for (int a = 1; a < 7; a++) begin
      wr(a[2:0], 8'h5A ^ a[7:0]);
      rd(a[2:0], d);
      chk("R2", d, 8'h5A ^ a[7:0]);
    end
    for (int a = 1; a < 7; a++) wr(a[2:0], 8'h00);

    // R5 latency and separation from output register
    wr(3'd1, 8'hFF);
    @(negedge clk_i);
    pin_i = 8'h3C;
    @(negedge clk_i);
    rd(3'd0, d);
    chk("R5", d, 8'h00);
    @(negedge clk_i);
    rd(3'd0, d);
    chk("R5", d, 8'h3C);
    repeat (2) @(negedge clk_i);
    m_flag = exp_hits(m_pin, 8'h3C, m_edge);
    m_pin = 8'h3C;
    rd(3'd7, d);
    chk("R6", d, m_flag);
    wr(3'd7, 8'h00);
    wr(3'd1, 8'h00);

    // R6 flag appears exactly on third edge
    @(negedge clk_i);
    pin_i = 8'h3D;
    repeat (2) @(negedge clk_i);
    rd(3'd7, d);
    chk("R6", d, 8'h00);
    @(negedge clk_i);
    rd(3'd7, d);
    chk("R6", d, 8'h01);
    m_pin = 8'h3D; m_flag = 8'h01;
    wr(3'd7, 8'h00);

    // R10 write of 0 in the same cycle as a rising edge
    @(negedge clk_i);
    pin_i = 8'h3F;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    reg_addr_i = 3'd7; reg_wdata_i = 8'h00; reg_we_i = 1;
    @(negedge clk_i);
    reg_we_i = 0;
    m_pin = 8'h3F; m_flag = 8'h02;
    repeat (2) @(negedge clk_i);
    rd(3'd7, d);
    chk("R10", d, 8'h02);

    // R9 set and clear by software, R8 irq
    wr(3'd7, 8'h80);
    rd(3'd7, d);
    chk("R9", d, 8'h80);
    chk("R8", {7'd0, irq_o}, 8'h00);
    wr(3'd6, 8'h80);
    chk("R8", {7'd0, irq_o}, 8'h01);
    wr(3'd7, 8'h00);
    chk("R9", {7'd0, irq_o}, 8'h00);

    // R11 polarity change with steady pins
    wr(3'd5, 8'hFF);
    wr(3'd5, 8'h0F);
    wr(3'd5, 8'hF0);
    repeat (3) @(negedge clk_i);
    rd(3'd7, d);
    chk("R11", d, 8'h00);

    // R7 falling polarity ignores rises
    wr(3'd5, 8'hFF);
    settle(8'hFF);
    rd(3'd7, d);
    chk("R7", d, 8'h00);
    settle(8'h0F);
    rd(3'd7, d);
    chk("R7", d, 8'hF0);
    wr(3'd7, 8'h00);

    // R3/R4/R12 directed pad cases
    alt_out_i = 8'hA5; alt_oe_i = 8'h3C;
    wr(3'd1, 8'hC3); wr(3'd2, 8'h0F); wr(3'd3, 8'hFF); wr(3'd4, 8'h00);
    check_pads("R3");
    wr(3'd4, 8'hFF);
    check_pads("R4");
    wr(3'd4, 8'h00);

    // randomized mix
    for (int it = 0; it < 60; it++) begin
      wr(3'd5, 8'($urandom));
      wr(3'd6, 8'($urandom));
      settle(8'($urandom));
      rd(3'd7, d);
      chk(m_edge[0] ? "R7" : "R6", d, m_flag);
      rd(3'd0, d);
      chk("R5", d, m_pin);
      chk("R8", {7'd0, irq_o}, {7'd0, |(m_flag & m_ien)});
      alt_out_i = 8'($urandom); alt_oe_i = 8'($urandom);
      wr(3'd1, 8'($urandom)); wr(3'd2, 8'($urandom));
      wr(3'd3, 8'($urandom)); wr(3'd4, 8'($urandom));
      check_pads(m_fsel[0] ? "R4" : "R3");
      if (it % 8 == 7) begin
        wr(3'd7, 8'h00);
        rd(3'd7, d);
        chk("R9", d, 8'h00);
      end
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule